// File: doc/BRIEF.md
# Vector byte window extract unit

This block slides a byte window across a pair of vector operands. The two operands are joined into one double-width value, with the first operand in the low half and the second in the high half. The result is the vector-width slice that starts at a byte index. The result therefore begins with the tail of the first operand, from the indexed byte upward, and the remaining bytes come from the bottom of the second operand. If the index is not below the vector length in bytes, it is taken as zero and the first operand passes through unchanged. Every result byte is written.

A 32-bit instruction word arrives on the same beat as the operands. A built-in decoder accepts two forms. In the destructive form, the destination is also the first source. In the constructive form, the two sources are a consecutive register pair and the destination is separate. The decoder puts the register numbers on combinational outputs, so that surrounding logic can fetch the operands within the same cycle. The decoder also rebuilds the 8-bit index from its two split fields. Each result is held in a single output register behind a valid/ready handshake, together with its destination register number. The vector size is set by the parameter `VL_BYTES`, from 16 to 256 bytes.

Top module: `vwin_extract_top`

## Requirements
- R1: When the index k is below VL_BYTES and k+j < VL_BYTES, result byte j equals byte k+j of `opa`.
- R2: When the index k is below VL_BYTES and k+j >= VL_BYTES, result byte j equals byte k+j-VL_BYTES of `opb`.
- R3: When the index is VL_BYTES or more (all 8 bits compared), the result equals `opa` unchanged.
- R4: The index is the 8-bit value {insn[20:16], insn[12:10]}, with insn[20:16] as its upper five bits.
- R5: A word with insn[31:21]=00000101001 is the destructive form. It drives `dec_dst` and `dec_src1` from insn[4:0] and `dec_src2` from insn[9:5].
- R6: A word with insn[31:21]=00000101011 is the constructive form. It drives `dec_src1` from insn[9:5], `dec_src2` with (insn[9:5]+1) mod 32, and `dec_dst` from insn[4:0].
- R7: A word that matches neither opcode, or has insn[15:13] nonzero, raises `dec_illegal` while `in_valid` is high. The beat is still consumed when `in_ready` is high, and it produces no result beat.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_dst` hold their values.
- R9: `in_ready` equals `!out_valid || out_ready`. A legal beat taken with `in_valid && in_ready` appears on `out_valid` on the next cycle. After reset, `out_valid` is low.
- R10: `out_dst` carries the destination register number of the beat that produced `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | Instruction word and operands are present |
| in_ready | output | 1 | The block can take a beat this cycle |
| insn | input | 32 | Instruction word |
| opa | input | VL_BYTES*8 | First source operand (low half of the pair) |
| opb | input | VL_BYTES*8 | Second source operand (high half of the pair) |
| dec_dst | output | 5 | Decoded destination register number |
| dec_src1 | output | 5 | Decoded first source register number |
| dec_src2 | output | 5 | Decoded second source register number |
| dec_illegal | output | 1 | The offered word is not a valid extract encoding |
| out_valid | output | 1 | Result register holds a beat |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | VL_BYTES*8 | Extracted window |
| out_dst | output | 5 | Destination register number of the result |

## Verification
The only state in this block is the output register and its valid flag. If the valid flag is wrong, a beat is lost, duplicated or overwritten, and this shows on `out_valid` or `in_ready` in the cycle right after the faulty edge. If the register loads at the wrong time, `out_data` changes while stalled, which is visible on the very next stalled cycle. Faults in the window datapath or the decoder have no state behind them. They show as wrong bytes or wrong register numbers in the same cycle (decode) or the next cycle (result). The model therefore compares every port on every clock, so that a fault shows up within one cycle of where it arises.

// File: rtl/vext_pkg.sv
package vext_pkg;

  localparam logic [10:0] OPC_DESTR = 11'b00000101001;
  localparam logic [10:0] OPC_CONSTR = 11'b00000101011;

  typedef struct packed {
    logic       legal;
    logic [7:0] idx;
    logic [4:0] dst;
    logic [4:0] src1;
    logic [4:0] src2;
  } vext_dec_t;

endpackage

// File: rtl/vext_decode.sv
module vext_decode
  import vext_pkg::*;
(
  input  logic [31:0] insn,
  output vext_dec_t   dec
);

  logic [10:0] opc;
  logic        is_destr;
  logic        is_constr;
  logic        gap_zero;

  assign opc       = insn[31:21];
  assign is_destr  = (opc == OPC_DESTR);
  assign is_constr = (opc == OPC_CONSTR);
  assign gap_zero  = (insn[15:13] == 3'b000);

  always_comb begin
    dec.legal = (is_destr || is_constr) && gap_zero;
    dec.idx   = {insn[20:16], insn[12:10]};
    dec.dst   = insn[4:0];
    if (is_constr) begin
      dec.src1 = insn[9:5];
      dec.src2 = insn[9:5] + 5'd1;
    end else begin
      dec.src1 = insn[4:0];
      dec.src2 = insn[9:5];
    end
  end

endmodule

// File: rtl/vext_funnel.sv
module vext_funnel #(
  parameter int VL_BYTES = 16
) (
  input  logic [7:0]            idx,
  input  logic [VL_BYTES*8-1:0] opa,
  input  logic [VL_BYTES*8-1:0] opb,
  output logic [VL_BYTES*8-1:0] win
);

  localparam int VL_BITS = VL_BYTES * 8;
  localparam int SELW    = $clog2(2 * VL_BYTES);

  logic [2*VL_BITS-1:0] pair;
  logic                 in_range;
  logic [SELW-1:0]      base;

  assign pair     = {opb, opa};
  assign in_range = (int'(idx) < VL_BYTES);
  assign base     = in_range ? SELW'(idx) : '0;

  for (genvar j = 0; j < VL_BYTES; j++) begin : g_byte
    logic [SELW-1:0] pos;
    assign pos = base + SELW'(j);
    assign win[j*8 +: 8] = pair[{pos, 3'b000} +: 8];
  end

endmodule

// File: rtl/vext_outreg.sv
module vext_outreg #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          drain,
  input  logic [DW-1:0] d_data,
  input  logic [4:0]    d_dst,
  output logic          q_valid,
  output logic [DW-1:0] q_data,
  output logic [4:0]    q_dst
);

  logic valid_nxt;
  logic data_en;

  always_comb begin
    data_en   = load;
    valid_nxt = q_valid;
    if (load) begin
      valid_nxt = 1'b1;
    end else if (drain) begin
      valid_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
    end else begin
      q_valid <= valid_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      q_data <= d_data;
      q_dst  <= d_dst;
    end
  end

endmodule

// File: rtl/vwin_extract_top.sv
module vwin_extract_top
  import vext_pkg::*;
#(
  parameter int VL_BYTES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [31:0]           insn,
  input  logic [VL_BYTES*8-1:0] opa,
  input  logic [VL_BYTES*8-1:0] opb,
  output logic [4:0]            dec_dst,
  output logic [4:0]            dec_src1,
  output logic [4:0]            dec_src2,
  output logic                  dec_illegal,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [VL_BYTES*8-1:0] out_data,
  output logic [4:0]            out_dst
);

  localparam int VL_BITS = VL_BYTES * 8;

  vext_dec_t          dec;
  logic [VL_BITS-1:0] win;
  logic               take;

  vext_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  vext_funnel #(.VL_BYTES(VL_BYTES)) u_fun (
    .idx (dec.idx),
    .opa (opa),
    .opb (opb),
    .win (win)
  );

  assign in_ready    = !out_valid || out_ready;
  assign take        = in_valid && in_ready && dec.legal;
  assign dec_illegal = in_valid && !dec.legal;
  assign dec_dst     = dec.dst;
  assign dec_src1    = dec.src1;
  assign dec_src2    = dec.src2;

  vext_outreg #(.DW(VL_BITS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take),
    .drain   (out_ready),
    .d_data  (win),
    .d_dst   (dec.dst),
    .q_valid (out_valid),
    .q_data  (out_data),
    .q_dst   (out_dst)
  );

endmodule

// File: rtl/vext_chk.sv
module vext_chk #(
  parameter int VL_BYTES = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  dec_illegal,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [VL_BYTES*8-1:0] out_data,
  input logic [4:0]            out_dst
);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_dst)));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  accept_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !dec_illegal) |=> out_valid);

  // R7
  illegal_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && dec_illegal) |=> !out_valid);

endmodule

bind vwin_extract_top vext_chk #(.VL_BYTES(VL_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .dec_illegal (dec_illegal),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_dst     (out_dst)
);

// File: tb/vwin_extract_top_tb.sv
`timescale 1ns/1ps
module vwin_extract_top_tb;

  localparam int VLB = 16;
  localparam int VW  = VLB * 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready, out_ready, out_valid, dec_illegal;
  logic [31:0]   insn;
  logic [VW-1:0] opa, opb, out_data;
  logic [4:0]    dec_dst, dec_src1, dec_src2, out_dst;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // behavioural model state
  bit            m_v;
  logic [VW-1:0] m_data;
  logic [4:0]    m_dst;
  string         m_tag;

  always #5 clk = ~clk;

  vwin_extract_top #(.VL_BYTES(VLB)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .opa(opa), .opb(opb), .dec_dst(dec_dst), .dec_src1(dec_src1),
    .dec_src2(dec_src2), .dec_illegal(dec_illegal), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_dst(out_dst)
  );

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] enc(input bit cons, input logic [7:0] k,
                                      input logic [4:0] m, input logic [4:0] d,
                                      input logic [2:0] gap);
    return {cons ? 11'b00000101011 : 11'b00000101001, k[7:3], gap, k[2:0], m, d};
  endfunction

  function automatic logic [VW-1:0] rvec();
    logic [VW-1:0] v;
    for (int b = 0; b < VLB; b++) v[b*8 +: 8] = 8'($urandom);
    return v;
  endfunction

  task automatic step(input bit v, input logic [31:0] w, input bit rdy);
    bit cons, legal, exp_rdy;
    int k;
    logic [VW-1:0] win;
    string tag;
    in_valid = v; insn = w; out_ready = rdy;
    opa = rvec(); opb = rvec();
    #1;
    cons    = (w[31:21] == 11'b00000101011);
    legal   = ((w[31:21] == 11'b00000101001) || cons) && (w[15:13] == 3'b000);
    exp_rdy = !m_v || rdy;
    chk(in_ready == exp_rdy, "R9 in_ready", VW'(in_ready), VW'(exp_rdy));
    chk(dec_illegal == (v && !legal), "R7 illegal", VW'(dec_illegal), VW'(v && !legal));
    if (legal) begin
      chk(dec_dst == w[4:0], "R5 R6 dst", VW'(dec_dst), VW'(w[4:0]));
      if (cons) begin
        chk(dec_src1 == w[9:5], "R6 src1", VW'(dec_src1), VW'(w[9:5]));
        chk(dec_src2 == 5'((int'(w[9:5]) + 1) % 32), "R6 src2", VW'(dec_src2),
            VW'((int'(w[9:5]) + 1) % 32));
      end else begin
        chk(dec_src1 == w[4:0], "R5 src1", VW'(dec_src1), VW'(w[4:0]));
        chk(dec_src2 == w[9:5], "R5 src2", VW'(dec_src2), VW'(w[9:5]));
      end
    end
    k = int'({w[20:16], w[12:10]});
    tag = (k >= VLB) ? "R3 R4" : (k == 0 ? "R1 R4" : "R1 R2 R4");
    for (int j = 0; j < VLB; j++) begin
      int s;
      s = (k >= VLB) ? j : k + j;
      win[j*8 +: 8] = (s < VLB) ? opa[s*8 +: 8] : opb[(s - VLB)*8 +: 8];
    end
    if (v && exp_rdy && legal) begin
      m_v = 1; m_data = win; m_dst = w[4:0]; m_tag = tag;
    end else if (rdy) begin
      m_v = 0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == m_v, "R8 R9 out_valid", VW'(out_valid), VW'(m_v));
    if (m_v && out_valid) begin
      chk(out_data == m_data, {m_tag, " out_data"}, out_data, m_data);
      chk(out_dst == m_dst, "R10 out_dst", VW'(out_dst), VW'(m_dst));
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    m_v = 0; m_tag = "";
    rst_n = 0; in_valid = 0; out_ready = 0; insn = '0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset out_valid", VW'(out_valid), '0);
    chk(in_ready == 1'b1, "R9 reset in_ready", VW'(in_ready), VW'(1));

    // R1 R2 R3 R4: index corners, destructive form
    step(1, enc(0, 8'd0,   5'd2, 5'd0, 3'd0), 1);
    step(1, enc(0, 8'd5,   5'd7, 5'd3, 3'd0), 1);
    step(1, enc(0, 8'd15,  5'd1, 5'd9, 3'd0), 1);
    step(1, enc(0, 8'd16,  5'd4, 5'd4, 3'd0), 1);
    step(1, enc(0, 8'd200, 5'd6, 5'd8, 3'd0), 1);
    step(1, enc(0, 8'd255, 5'd6, 5'd8, 3'd0), 1);
    step(1, enc(0, 8'd9,   5'd6, 5'd8, 3'd0), 1);
    // R6: pair wraps from 31 to 0
    step(1, enc(1, 8'd12, 5'd31, 5'd17, 3'd0), 1);
    step(1, enc(1, 8'd3,  5'd10, 5'd30, 3'd0), 1);
    // R7: bad opcode, nonzero gap field
    step(1, 32'hFFFF_FFFF, 1);
    step(1, enc(0, 8'd4, 5'd1, 5'd1, 3'd2), 1);
    step(1, enc(1, 8'd4, 5'd1, 5'd1, 3'd7), 1);
    step(0, enc(0, 8'd4, 5'd1, 5'd1, 3'd0), 1);
    // R8: stall with new beats offered
    step(1, enc(0, 8'd6, 5'd2, 5'd21, 3'd0), 0);
    step(1, enc(0, 8'd7, 5'd3, 5'd22, 3'd0), 0);
    step(1, enc(1, 8'd8, 5'd4, 5'd23, 3'd0), 0);
    step(1, 32'h1234_5678, 0);
    step(0, 32'h0, 1);
    step(0, 32'h0, 1);

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] w;
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 7)
        w = enc(r[0], 8'($urandom), 5'($urandom), 5'($urandom), 3'd0);
      else if (r == 7)
        w = enc(r[0], 8'($urandom), 5'($urandom), 5'($urandom), 3'($urandom_range(1, 7)));
      else
        w = $urandom;
      step($urandom_range(0, 4) != 0, w, $urandom_range(0, 9) < 7);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule